// File: doc/BRIEF.md
# Cascadable Nibble Arithmetic Slice

The block is a 4-bit arithmetic cell built around one ripple carry chain. A static two-bit mode input picks what the chain does. It can step a counter up or down, or perform one 4-by-1 multiply-and-accumulate step. It can also compare two nibbles for equality, or pass the A nibble straight through. The fifth A bit has a different meaning in each mode: in counter mode it is the count direction, and in multiply-accumulate mode it is the multiplier bit.

The slice produces a combinational result `f_comb`, a registered copy `f_reg` and a carry output. Several slices chain into wider datapaths by wiring each slice's `carry_out` to the next slice's `carry_in`:

- In multiply-accumulate mode the carry is the addition overflow.
- In equality mode the carry is a running "differs" flag.
- The parameter `FIRST_SLICE` marks the least significant slice of a chain. In equality mode that slice ignores its carry input.

In counter mode the slice's own register holds the count. The combinational result is therefore always the registered value stepped by one, so the slice counts each cycle that the enable is high.

Top module: `nib_arith_slice`

## Requirements
- R1: In counter mode (`mode_sel`=2'b00) `f_comb` equals `f_reg`+1 modulo 16 when `a_in[4]`=1 and `f_reg`-1 modulo 16 when `a_in[4]`=0. `a_in[3:0]`, `b_in` and `carry_in` have no effect in this mode.
- R2: In counter mode `carry_out` is 1 exactly on wrap: counting up from 4'b1111, or counting down from 4'b0000.
- R3: In multiply-accumulate mode (`mode_sel`=2'b01) with `a_in[4]`=1, {`carry_out`,`f_comb`} equals `a_in[3:0]` + `b_in` + `carry_in` as a 5-bit sum.
- R4: In multiply-accumulate mode with `a_in[4]`=0, {`carry_out`,`f_comb`} equals `a_in[3:0]` + `carry_in`, and `b_in` has no effect.
- R5: In equality mode (`mode_sel`=2'b10) `f_comb` equals `a_in[3:0]` XOR `b_in`. `carry_out` is 1 when the nibbles differ or when the effective carry input is 1, and is 0 otherwise. When `FIRST_SLICE`=0 the effective carry input is `carry_in`.
- R6: With `FIRST_SLICE`=1, `carry_in` is forced to 0 in equality mode, so equal nibbles give `carry_out`=0 whatever `carry_in` is.
- R7: In pass mode (`mode_sel`=2'b11) `f_comb` equals `a_in[3:0]` and `carry_out` is 0.
- R8: On a rising clock edge with `rst_sync`=0 and `clk_en`=1, `f_reg` loads the value `f_comb` had before the edge.
- R9: On a rising clock edge with `rst_sync`=0 and `clk_en`=0, `f_reg` keeps its value.
- R10: On a rising clock edge with `rst_sync`=1, `f_reg` becomes 0 regardless of `clk_en`.
- R11: After reset `f_reg` reads 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_sync | input | 1 | Synchronous reset of the output register, active high |
| clk_en | input | 1 | Load enable of the output register |
| mode_sel | input | 2 | Submode: 00 counter, 01 multiply-accumulate, 10 equality, 11 pass |
| a_in | input | 5 | Bits 3:0 are the operand or partial product; bit 4 is the direction or multiplier bit |
| b_in | input | 4 | Multiplicand or second compare operand |
| carry_in | input | 1 | Carry or mismatch from the less significant slice |
| f_comb | output | 4 | Combinational result |
| f_reg | output | 4 | Registered result |
| carry_out | output | 1 | Carry, wrap or mismatch to the next slice |

## Verification
`f_comb` and `carry_out` are due in the same cycle as the stimulus. They include the carry that ripples from the low slice into a second, non-first slice. The bench samples them one time unit after driving the inputs on the falling edge, which is well before the next rising edge. `f_reg` is due at the first rising edge after the stimulus, so it is checked one time unit past that edge against a bench-side model of the register. In counter mode the stepped value appears in `f_comb` right after that same edge, so the next step's combinational check also confirms the feedback path.

// File: rtl/nas_pkg.sv
package nas_pkg;
    typedef enum logic [1:0] {
        MODE_COUNT = 2'b00,
        MODE_MAC   = 2'b01,
        MODE_EQ    = 2'b10,
        MODE_PASS  = 2'b11
    } nas_mode_e;
endpackage

// File: rtl/nas_ripple_adder.sv
module nas_ripple_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         ci_i,
    output logic [W-1:0] s_o,
    output logic         co_o
);
    logic [W:0] chain;

    assign chain[0] = ci_i;

    for (genvar k = 0; k < W; k++) begin : g_bit
        logic prop;
        logic gen;
        assign prop       = x_i[k] ^ y_i[k];
        assign gen        = x_i[k] & y_i[k];
        assign s_o[k]     = prop ^ chain[k];
        assign chain[k+1] = gen | (prop & chain[k]);
    end

    assign co_o = chain[W];
endmodule

// File: rtl/nas_submode_ctl.sv
module nas_submode_ctl
    import nas_pkg::*;
#(
    parameter int W           = 4,
    parameter bit FIRST_SLICE = 1'b1
) (
    input  nas_mode_e    mode_i,
    input  logic         ctl_bit_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [W-1:0] count_q_i,
    output logic [W-1:0] add_x_o,
    output logic [W-1:0] add_y_o,
    output logic         add_ci_o,
    input  logic [W-1:0] add_s_i,
    input  logic         add_co_i,
    output logic [W-1:0] f_o,
    output logic         cout_o
);
    logic         cin_eff;
    logic [W-1:0] diff_bits;
    logic         mismatch;

    if (FIRST_SLICE) begin : g_first
        assign cin_eff = 1'b0;
    end else begin : g_chained
        assign cin_eff = cin_i;
    end

    assign diff_bits = a_i ^ b_i;
    assign mismatch  = |diff_bits;

    // Operand selection for the shared carry chain
    always_comb begin
        add_x_o  = '0;
        add_y_o  = '0;
        add_ci_o = 1'b0;
        unique case (mode_i)
            MODE_COUNT: begin
                add_x_o  = count_q_i;
                add_y_o  = ctl_bit_i ? '0 : '1;  // minus one as all-ones
                add_ci_o = ctl_bit_i;
            end
            MODE_MAC: begin
                add_x_o  = a_i;
                add_y_o  = ctl_bit_i ? b_i : '0;
                add_ci_o = cin_i;
            end
            default: begin
                add_x_o  = '0;
                add_y_o  = '0;
                add_ci_o = 1'b0;
            end
        endcase
    end

    // Result and carry-out selection
    always_comb begin
        f_o    = '0;
        cout_o = 1'b0;
        unique case (mode_i)
            MODE_COUNT: begin
                f_o    = add_s_i;
                cout_o = ctl_bit_i ? add_co_i : ~add_co_i;
            end
            MODE_MAC: begin
                f_o    = add_s_i;
                cout_o = add_co_i;
            end
            MODE_EQ: begin
                f_o    = diff_bits;
                cout_o = mismatch | cin_eff;
            end
            default: begin
                f_o    = a_i;
                cout_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/nas_out_reg.sv
module nas_out_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] val;
    } reg_state_t;

    reg_state_t st_d;
    reg_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.val = '0;
        end else if (en_i) begin
            st_d.val = d_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = st_q.val;

    // R10
    reset_clear_chk: assert property (@(posedge clk) rst_i |=> (q_o == '0));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst_i)
        (!en_i) |=> $stable(q_o));

    // R8
    load_on_enable_chk: assert property (@(posedge clk) disable iff (rst_i)
        en_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/nib_arith_slice.sv
module nib_arith_slice
    import nas_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter bit FIRST_SLICE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_sync,
    input  logic             clk_en,
    input  logic [1:0]       mode_sel,
    input  logic [NIB_W:0]   a_in,
    input  logic [NIB_W-1:0] b_in,
    input  logic             carry_in,
    output logic [NIB_W-1:0] f_comb,
    output logic [NIB_W-1:0] f_reg,
    output logic             carry_out
);
    localparam int CTL_IDX = NIB_W;

    nas_mode_e        mode;
    logic [NIB_W-1:0] add_x;
    logic [NIB_W-1:0] add_y;
    logic             add_ci;
    logic [NIB_W-1:0] add_s;
    logic             add_co;

    assign mode = nas_mode_e'(mode_sel);

    nas_submode_ctl #(
        .W           (NIB_W),
        .FIRST_SLICE (FIRST_SLICE)
    ) u_ctl (
        .mode_i    (mode),
        .ctl_bit_i (a_in[CTL_IDX]),
        .a_i       (a_in[NIB_W-1:0]),
        .b_i       (b_in),
        .cin_i     (carry_in),
        .count_q_i (f_reg),
        .add_x_o   (add_x),
        .add_y_o   (add_y),
        .add_ci_o  (add_ci),
        .add_s_i   (add_s),
        .add_co_i  (add_co),
        .f_o       (f_comb),
        .cout_o    (carry_out)
    );

    nas_ripple_adder #(
        .W (NIB_W)
    ) u_chain (
        .x_i  (add_x),
        .y_i  (add_y),
        .ci_i (add_ci),
        .s_o  (add_s),
        .co_o (add_co)
    );

    nas_out_reg #(
        .W (NIB_W)
    ) u_reg (
        .clk   (clk),
        .rst_i (rst_sync),
        .en_i  (clk_en),
        .d_i   (f_comb),
        .q_o   (f_reg)
    );

    // R2
    count_wrap_flag_chk: assert property (@(posedge clk) disable iff (rst_sync)
        (mode == MODE_COUNT) |->
            (carry_out == (a_in[CTL_IDX] ? (f_comb == '0) : (f_comb == '1))));

    // R5
    eq_mismatch_chk: assert property (@(posedge clk) disable iff (rst_sync)
        (mode == MODE_EQ && a_in[NIB_W-1:0] != b_in) |-> carry_out);

    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (rst_sync)
        (mode == MODE_PASS) |-> (!carry_out && f_comb == a_in[NIB_W-1:0]));

    if (FIRST_SLICE) begin : g_first_chk
        // R6
        first_cin_ignored_chk: assert property (@(posedge clk) disable iff (rst_sync)
            (mode == MODE_EQ && a_in[NIB_W-1:0] == b_in) |-> !carry_out);
    end
endmodule

// File: tb/tb_nib_arith_slice.sv
module tb_nib_arith_slice;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, en, cin;
    logic [1:0] mode;
    logic [4:0] a_lo, a_hi;
    logic [3:0] b_lo, b_hi;
    logic [3:0] f_lo, r_lo, f_hi, r_hi;
    logic       c_lo, c_hi;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    logic [3:0] q_lo = 4'h0;
    logic [3:0] q_hi = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_arith_slice #(.NIB_W(4), .FIRST_SLICE(1'b1)) dut (
        .clk(clk), .rst_sync(rst), .clk_en(en), .mode_sel(mode),
        .a_in(a_lo), .b_in(b_lo), .carry_in(cin),
        .f_comb(f_lo), .f_reg(r_lo), .carry_out(c_lo));

    nib_arith_slice #(.NIB_W(4), .FIRST_SLICE(1'b0)) dut_hi (
        .clk(clk), .rst_sync(rst), .clk_en(en), .mode_sel(mode),
        .a_in(a_hi), .b_in(b_hi), .carry_in(c_lo),
        .f_comb(f_hi), .f_reg(r_hi), .carry_out(c_hi));

    function automatic logic [4:0] model(input logic [1:0] m, input logic [4:0] a,
                                         input logic [3:0] b, input logic ci,
                                         input logic [3:0] q, input bit first);
        logic [4:0] r;
        case (m)
            2'b00: begin
                if (a[4]) r = {q == 4'hF, q + 4'd1};
                else      r = {q == 4'h0, q - 4'd1};
            end
            2'b01:   r = {1'b0, a[3:0]} + {1'b0, (a[4] ? b : 4'h0)} + {4'h0, ci};
            2'b10:   r = {(a[3:0] != b) | (first ? 1'b0 : ci), a[3:0] ^ b};
            default: r = {1'b0, a[3:0]};
        endcase
        return r;
    endfunction

    function automatic string comb_tag(input logic [1:0] m, input logic a4);
        case (m)
            2'b00:   return "R1";
            2'b01:   return a4 ? "R3" : "R4";
            2'b10:   return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic [1:0] m,
                        input logic [4:0] al, input logic [3:0] bl, input logic ci,
                        input logic [4:0] ah, input logic [3:0] bh);
        logic [4:0] xl, xh;
        string tl, th, rt;
        rst = r; en = e; mode = m; a_lo = al; b_lo = bl; cin = ci; a_hi = ah; b_hi = bh;
        #1;
        xl = model(m, al, bl, ci, q_lo, 1'b1);
        xh = model(m, ah, bh, xl[4], q_hi, 1'b0);
        tl = comb_tag(m, al[4]);
        th = comb_tag(m, ah[4]);
        check(tl, "lo f_comb", {4'h0, f_lo}, {4'h0, xl[3:0]});
        check((m == 2'b00) ? "R2" : tl, "lo carry_out", {7'h0, c_lo}, {7'h0, xl[4]});
        check(th, "hi f_comb", {4'h0, f_hi}, {4'h0, xh[3:0]});
        check((m == 2'b00) ? "R2" : th, "hi carry_out", {7'h0, c_hi}, {7'h0, xh[4]});
        @(posedge clk);
        #1;
        if (r) begin
            q_lo = 4'h0; q_hi = 4'h0; rt = "R10";
        end else if (e) begin
            q_lo = xl[3:0]; q_hi = xh[3:0]; rt = "R8";
        end else begin
            rt = "R9";
        end
        check(rt, "lo f_reg", {4'h0, r_lo}, {4'h0, q_lo});
        check(rt, "hi f_reg", {4'h0, r_hi}, {4'h0, q_hi});
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        rst = 1'b1; en = 1'b0; cin = 1'b0; mode = 2'b11;
        a_lo = 5'h0; b_lo = 4'h0; a_hi = 5'h0; b_hi = 4'h0;
        void'($urandom(seed));
        @(negedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", "lo f_reg after reset", {4'h0, r_lo}, 8'h00);
        check("R11", "hi f_reg after reset", {4'h0, r_hi}, 8'h00);

        // R8 load via pass mode, then R10 reset beats enable
        step(1'b0, 1'b1, 2'b11, 5'h05, 4'h0, 1'b0, 5'h0A, 4'h0);
        step(1'b1, 1'b1, 2'b11, 5'h09, 4'h0, 1'b0, 5'h03, 4'h0);
        // R9 hold with enable low, differing inputs
        step(1'b0, 1'b1, 2'b11, 5'h07, 4'h0, 1'b0, 5'h0C, 4'h0);
        step(1'b0, 1'b0, 2'b11, 5'h02, 4'h9, 1'b1, 5'h01, 4'h6);

        // Counter: clear, count down from zero (R2 wrap), then up through 1111 (R2)
        step(1'b1, 1'b0, 2'b00, 5'h00, 4'h0, 1'b0, 5'h00, 4'h0);
        step(1'b0, 1'b1, 2'b00, 5'h05, 4'h3, 1'b1, 5'h0E, 4'h1);
        for (int i = 0; i < 18; i++) begin
            step(1'b0, 1'b1, 2'b00, {1'b1, 4'(i)}, 4'(i * 3), 1'(i), 5'h10, 4'h0);
        end

        // R3/R4 directed multiply-accumulate overflow and pass-through
        step(1'b0, 1'b1, 2'b01, 5'h1F, 4'hF, 1'b1, 5'h1F, 4'hF);
        step(1'b0, 1'b1, 2'b01, 5'h0F, 4'hF, 1'b1, 5'h03, 4'hA);

        // R5/R6: 8-bit equal, low differs only, first slice with carry_in=1
        step(1'b0, 1'b1, 2'b10, 5'h0A, 4'hA, 1'b0, 5'h03, 4'h3);
        step(1'b0, 1'b1, 2'b10, 5'h0A, 4'hB, 1'b0, 5'h03, 4'h3);
        step(1'b0, 1'b1, 2'b10, 5'h16, 4'h6, 1'b1, 5'h15, 4'h5);
        check("R6", "first slice equal with carry_in=1", {7'h0, c_lo}, 8'h00);

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] v;
            v = $urandom();
            step((v[31:28] == 4'h0), (v[27:26] != 2'b00), v[1:0],
                 v[6:2], v[10:7], v[11], v[16:12], v[20:17]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule